// File: doc/BRIEF.md
# DSI Command Packet Assembler

This block turns one host command request into writes to the transmit FIFOs of a DSI link controller. A request carries a data type (or a flag that asks the block to pick the command-write type from the length), a virtual channel, a byte count, and a separate stream of bytes. The block chooses short or long format from the data type. For a long packet it packs the bytes four at a time into 32-bit words, least significant byte first, and pushes them to a payload-word port. It then pushes a single 32-bit header word to a header port.

Every port uses a valid/ready handshake. The request stays pending until its header word has been taken. Malformed requests get a one-cycle error pulse instead, and nothing is written for them. If a long payload is larger than the configured FIFO depth, a warning output is raised, but the transfer still goes ahead.

Top module: `dsi_cmd_pkt_asm`

## Requirements
- R1: The header word carries the identifier in bits 7:0, byte 1 in bits 15:8, byte 2 in bits 23:16, and zero in bits 31:24. The identifier holds the data type in bits 5:0 and the virtual channel in bits 7:6.
- R2: A data type whose low four bits are 0 to 8 gives a short packet. Low bits 9 to 15 give a long packet.
- R3: In a short packet, header byte 1 is the first stream byte. Header byte 2 is the second stream byte when the length is 2, and zero when the length is 1. A short packet pushes no payload word.
- R4: A short-format request with a length above 2 is rejected.
- R5: In a long packet, header byte 1 is bits 7:0 of the length and header byte 2 is bits 15:8 of the length.
- R6: Long payload bytes go into words in stream order. Byte n of a group sits in bits 8n+7:8n. A final group of 1 to 3 bytes fills the low bytes, and the unused upper bytes are zero.
- R7: Every payload word of a request is accepted before its header word is offered. req_ready rises in the cycle after the header handshake.
- R8: A zero-length request is rejected. It writes nothing and consumes no stream byte.
- R9: With auto_type set, the type is 0x05 for length 1, 0x15 for length 2, and 0x39 for any longer length.
- R10: ovf_warn is high from the cycle after a long request with a length above FIFO_BYTES is captured, up to and including its acknowledge cycle. The packet is still sent in full.
- R11: A rejected request gets err_pulse high for exactly one cycle, together with req_ready. The block then returns to idle, and no byte of that request is consumed.
- R12: While pw_valid or hdr_valid is high and the matching ready is low, the valid stays high and the data stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request done (sent or rejected) |
| req_dtype | input | 6 | Data type when auto_type is low |
| req_auto_type | input | 1 | Pick the command-write type from the length |
| req_vc | input | 2 | Virtual channel |
| req_len | input | LEN_W | Byte count |
| byte_valid | input | 1 | Stream byte present |
| byte_ready | output | 1 | Stream byte taken |
| byte_data | input | 8 | Stream byte |
| pw_valid | output | 1 | Payload word offered |
| pw_ready | input | 1 | Payload FIFO accepts |
| pw_data | output | 32 | Payload word |
| hdr_valid | output | 1 | Header word offered |
| hdr_ready | input | 1 | Header FIFO accepts |
| hdr_data | output | 32 | Header word |
| err_pulse | output | 1 | Request rejected |
| ovf_warn | output | 1 | Long payload exceeds FIFO depth |

## Verification
Short requests of one and two bytes, on several channels, check how the header parameters are built and confirm that no payload is written. Types with low nibble 8 and 9 mark the boundary between short and long format. Long lengths of 1, 4, 5, 6 and 7 separate a full word from each zero-filled tail. Auto-typed lengths 1, 2 and 3 check the type choice. Zero-length and three-byte short requests check rejection. A 70-byte transfer under ready backpressure, compared with a 64-byte one, checks the overflow warning and the word order while the FIFOs stall.

// File: rtl/dsi_pkt_pkg.sv
package dsi_pkt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_GATHER = 3'd1,
    ST_PUSHW  = 3'd2,
    ST_HDR    = 3'd3,
    ST_ACK    = 3'd4,
    ST_REJECT = 3'd5
  } asm_state_e;

  localparam logic [5:0] DT_CMD_SHORT   = 6'h05;
  localparam logic [5:0] DT_CMD_SHORT_P = 6'h15;
  localparam logic [5:0] DT_CMD_LONG    = 6'h39;
  localparam int unsigned SHORT_MAX_BYTES = 2;

  function automatic logic type_is_short(input logic [5:0] dt);
    return (dt[3:0] < 4'd9);
  endfunction
endpackage

// File: rtl/dsi_req_decode.sv
module dsi_req_decode import dsi_pkt_pkg::*; #(
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned FIFO_BYTES = 64
) (
  input  logic [5:0]       dtype,
  input  logic             auto_type,
  input  logic [LEN_W-1:0] len,
  output logic [5:0]       eff_type,
  output logic             is_short,
  output logic             bad,
  output logic             ovf
);
  always_comb begin
    if (auto_type) begin
      if (len == LEN_W'(1))      eff_type = DT_CMD_SHORT;
      else if (len == LEN_W'(2)) eff_type = DT_CMD_SHORT_P;
      else                       eff_type = DT_CMD_LONG;
    end else begin
      eff_type = dtype;
    end
    is_short = type_is_short(eff_type);
    bad      = (len == '0) || (is_short && (len > LEN_W'(SHORT_MAX_BYTES)));
    ovf      = !is_short && !bad && (len > LEN_W'(FIFO_BYTES));
  end
endmodule

// File: rtl/dsi_word_packer.sv
module dsi_word_packer #(
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    take,
  input  logic [7:0]              din,
  output logic [8*WORD_BYTES-1:0] word,
  output logic                    lane_last
);
  localparam int unsigned LANE_W = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;

  logic [LANE_W-1:0] lane_q, lane_d;
  logic [7:0]        byte_q [WORD_BYTES];
  logic [7:0]        byte_d [WORD_BYTES];

  assign lane_last = (lane_q == LANE_W'(WORD_BYTES-1));

  always_comb begin
    lane_d = lane_q;
    if (clr)       lane_d = '0;
    else if (take) lane_d = lane_last ? '0 : lane_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lane_q <= '0;
    else        lane_q <= lane_d;
  end

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    always_comb begin
      byte_d[g] = byte_q[g];
      if (clr)                                         byte_d[g] = 8'h00;
      else if (take && (lane_q == LANE_W'(g)))         byte_d[g] = din;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q[g] <= 8'h00;
      else        byte_q[g] <= byte_d[g];
    end
    assign word[8*g +: 8] = byte_q[g];
  end
endmodule

// File: rtl/dsi_cmd_pkt_asm.sv
module dsi_cmd_pkt_asm import dsi_pkt_pkg::*; #(
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned FIFO_BYTES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [5:0]       req_dtype,
  input  logic             req_auto_type,
  input  logic [1:0]       req_vc,
  input  logic [LEN_W-1:0] req_len,
  input  logic             byte_valid,
  output logic             byte_ready,
  input  logic [7:0]       byte_data,
  output logic             pw_valid,
  input  logic             pw_ready,
  output logic [31:0]      pw_data,
  output logic             hdr_valid,
  input  logic             hdr_ready,
  output logic [31:0]      hdr_data,
  output logic             err_pulse,
  output logic             ovf_warn
);
  asm_state_e       state_q, state_d;
  logic [5:0]       type_q, type_d;
  logic [1:0]       vc_q, vc_d;
  logic [LEN_W-1:0] len_q, len_d, rem_q, rem_d;
  logic             short_q, short_d, ovf_q, ovf_d;

  logic [5:0]  dec_type;
  logic        dec_short, dec_bad, dec_ovf;
  logic        pk_clr, pk_take, pk_last;
  logic [31:0] pk_word;
  logic [15:0] len16;

  dsi_req_decode #(.LEN_W(LEN_W), .FIFO_BYTES(FIFO_BYTES)) u_dec (
    .dtype(req_dtype), .auto_type(req_auto_type), .len(req_len),
    .eff_type(dec_type), .is_short(dec_short), .bad(dec_bad), .ovf(dec_ovf)
  );

  dsi_word_packer #(.WORD_BYTES(4)) u_pack (
    .clk(clk), .rst_n(rst_n), .clr(pk_clr), .take(pk_take),
    .din(byte_data), .word(pk_word), .lane_last(pk_last)
  );

  assign byte_ready = (state_q == ST_GATHER);
  assign pw_valid   = (state_q == ST_PUSHW);
  assign hdr_valid  = (state_q == ST_HDR);
  assign req_ready  = (state_q == ST_ACK) || (state_q == ST_REJECT);
  assign err_pulse  = (state_q == ST_REJECT);
  assign ovf_warn   = ovf_q;
  assign pw_data    = pk_word;
  assign pk_take    = byte_ready && byte_valid;
  assign pk_clr     = (state_q == ST_IDLE) || (pw_valid && pw_ready);
  assign len16      = 16'(len_q);

  always_comb begin
    if (short_q) hdr_data = {8'h00, pk_word[15:8], pk_word[7:0], vc_q, type_q};
    else         hdr_data = {8'h00, len16[15:8], len16[7:0], vc_q, type_q};
  end

  always_comb begin
    state_d = state_q;
    type_d  = type_q;
    vc_d    = vc_q;
    len_d   = len_q;
    rem_d   = rem_q;
    short_d = short_q;
    ovf_d   = ovf_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          type_d  = dec_type;
          vc_d    = req_vc;
          len_d   = req_len;
          rem_d   = req_len;
          short_d = dec_short;
          ovf_d   = dec_ovf;
          state_d = dec_bad ? ST_REJECT : ST_GATHER;
        end
      end
      ST_GATHER: begin
        if (pk_take) begin
          rem_d = rem_q - 1'b1;
          if ((rem_q == LEN_W'(1)) || pk_last) state_d = short_q ? ST_HDR : ST_PUSHW;
        end
      end
      ST_PUSHW: begin
        if (pw_ready) state_d = (rem_q == '0) ? ST_HDR : ST_GATHER;
      end
      ST_HDR: begin
        if (hdr_ready) state_d = ST_ACK;
      end
      ST_ACK: begin
        ovf_d   = 1'b0;
        state_d = ST_IDLE;
      end
      ST_REJECT: begin
        ovf_d   = 1'b0;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      type_q  <= '0;
      vc_q    <= '0;
      len_q   <= '0;
      rem_q   <= '0;
      short_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      type_q  <= type_d;
      vc_q    <= vc_d;
      len_q   <= len_d;
      rem_q   <= rem_d;
      short_q <= short_d;
      ovf_q   <= ovf_d;
    end
  end
endmodule

// File: rtl/dsi_cmd_pkt_asm_chk.sv
module dsi_cmd_pkt_asm_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        byte_ready,
  input logic        pw_valid,
  input logic        pw_ready,
  input logic [31:0] pw_data,
  input logic        hdr_valid,
  input logic        hdr_ready,
  input logic [31:0] hdr_data,
  input logic        err_pulse,
  input logic        ovf_warn
);
  AST_PW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pw_valid && !pw_ready |=> pw_valid && $stable(pw_data)); // R12
  AST_HDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && !hdr_ready |=> hdr_valid && $stable(hdr_data)); // R12
  AST_ACK_AFTER_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready && !err_pulse |-> $past(hdr_valid && hdr_ready)); // R7
  AST_ERR_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> req_ready |=> !err_pulse); // R11
  AST_ONE_ACTIVITY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({byte_ready, pw_valid, hdr_valid, req_ready})); // R7
  AST_OVF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_warn && !req_ready |=> ovf_warn); // R10
  AST_HDR_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |-> hdr_data[31:24] == 8'h00); // R1
endmodule

bind dsi_cmd_pkt_asm dsi_cmd_pkt_asm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .byte_ready(byte_ready),
  .pw_valid(pw_valid), .pw_ready(pw_ready), .pw_data(pw_data),
  .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_data(hdr_data),
  .err_pulse(err_pulse), .ovf_warn(ovf_warn)
);

// File: tb/dsi_cmd_pkt_asm_bench.sv
module dsi_cmd_pkt_asm_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_auto_type = 1'b0;
  logic [5:0] req_dtype = '0;
  logic [1:0] req_vc = '0;
  logic [15:0] req_len = '0;
  logic byte_valid = 1'b0;
  logic [7:0] byte_data = '0;
  logic pw_ready = 1'b0, hdr_ready = 1'b0;
  logic req_ready, byte_ready, pw_valid, hdr_valid, err_pulse, ovf_warn;
  logic [31:0] pw_data, hdr_data;

  int compared = 0, mismatched = 0, cyc = 0;
  bit bp_on = 1'b0;
  logic [31:0] exp_pw[$];
  logic [31:0] exp_hdr[$];
  logic [7:0] bbuf [0:127];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dsi_cmd_pkt_asm u_dsi_cmd_pkt_asm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_dtype(req_dtype), .req_auto_type(req_auto_type), .req_vc(req_vc),
    .req_len(req_len), .byte_valid(byte_valid), .byte_ready(byte_ready),
    .byte_data(byte_data), .pw_valid(pw_valid), .pw_ready(pw_ready),
    .pw_data(pw_data), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .hdr_data(hdr_data), .err_pulse(err_pulse), .ovf_warn(ovf_warn)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: drives ready patterns, compares accepted words against scoreboard
  initial forever begin
    @(negedge clk);
    pw_ready  = bp_on ? (cyc % 3 != 0) : 1'b1;
    hdr_ready = bp_on ? (cyc % 2 == 0) : 1'b1;
    #5;
    if (pw_valid && pw_ready) begin
      if (exp_pw.size() == 0) chk(0, "R3/R6 unexpected payload word", pw_data, 0);
      else begin
        logic [31:0] e;
        e = exp_pw.pop_front();
        chk(pw_data == e, "R6 payload word", pw_data, e);
      end
    end
    if (hdr_valid && hdr_ready) begin
      chk(exp_pw.size() == 0, "R7 header before payload done", exp_pw.size(), 0);
      if (exp_hdr.size() == 0) chk(0, "R8 unexpected header", hdr_data, 0);
      else begin
        logic [31:0] e;
        e = exp_hdr.pop_front();
        chk(hdr_data == e, "R1 header word", hdr_data, e);
      end
    end
  end

  task automatic send(input logic [5:0] dt, input bit aut, input logic [1:0] vc,
                      input int len, input string tag);
    logic [5:0] t;
    bit sh, rej, ovf_exp, seen_ovf, got_err;
    int idx;
    if (aut) t = (len == 1) ? 6'h05 : (len == 2) ? 6'h15 : 6'h39;
    else     t = dt;
    sh  = (t[3:0] < 4'd9);
    rej = (len == 0) || (sh && len > 2);
    ovf_exp = !rej && !sh && (len > 64);
    if (!rej) begin
      if (sh) exp_hdr.push_back({8'h00, (len == 2) ? bbuf[1] : 8'h00, bbuf[0], vc, t});
      else begin
        for (int i = 0; i < len; i += 4) begin
          logic [31:0] w;
          w = '0;
          for (int k = 0; k < 4; k++) if (i + k < len) w[8*k +: 8] = bbuf[i+k];
          exp_pw.push_back(w);
        end
        exp_hdr.push_back({8'h00, 8'(len >> 8), 8'(len), vc, t});
      end
    end
    @(negedge clk);
    req_valid = 1'b1; req_dtype = dt; req_auto_type = aut; req_vc = vc; req_len = 16'(len);
    idx = 0; seen_ovf = 0; got_err = 0;
    forever begin
      byte_valid = (idx < len);
      byte_data  = bbuf[idx % 128];
      #5;
      if (byte_valid && byte_ready) idx++;
      if (ovf_warn) seen_ovf = 1;
      if (req_ready) begin
        got_err = err_pulse;
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    req_valid = 1'b0; byte_valid = 1'b0;
    chk(got_err == rej, {tag, " reject flag R11"}, got_err, rej);
    chk(idx == (rej ? 0 : len), {tag, " bytes consumed R8"}, idx, rej ? 0 : len);
    chk(seen_ovf == ovf_exp, {tag, " overflow warn R10"}, seen_ovf, ovf_exp);
    repeat (3) @(negedge clk);
    chk(exp_hdr.size() == 0 && exp_pw.size() == 0, {tag, " scoreboard drained R7"},
        exp_hdr.size() + exp_pw.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) bbuf[i] = 8'(i * 37 + 11);
    repeat (3) @(negedge clk);
    #5;
    chk({req_ready, byte_ready, pw_valid, hdr_valid, err_pulse, ovf_warn} == 6'b0,
        "reset outputs idle", {req_ready, byte_ready, pw_valid, hdr_valid, err_pulse, ovf_warn}, 0);
    rst_n = 1'b1;
    send(6'h05, 0, 2'd0, 1, "R3 short 1B");
    send(6'h15, 0, 2'd2, 2, "R3 short 2B vc2");
    send(6'h08, 0, 2'd3, 2, "R2 nibble8 short");
    send(6'h09, 0, 2'd1, 1, "R2 nibble9 long");
    send(6'h29, 0, 2'd0, 4, "R6 full word");
    send(6'h39, 0, 2'd1, 5, "R6 tail1");
    send(6'h39, 0, 2'd2, 6, "R6 tail2");
    send(6'h1F, 0, 2'd3, 7, "R5 tail3");
    send(6'h00, 1, 2'd1, 1, "R9 auto 1");
    send(6'h00, 1, 2'd2, 2, "R9 auto 2");
    send(6'h00, 1, 2'd0, 3, "R9 auto 3");
    send(6'h39, 0, 2'd0, 0, "R8 zero len");
    send(6'h05, 0, 2'd0, 3, "R4 short 3B");
    send(6'h00, 1, 2'd0, 0, "R8 auto zero");
    bp_on = 1'b1;
    send(6'h39, 0, 2'd2, 70, "R10 over depth");
    send(6'h39, 0, 2'd1, 64, "R10 at depth");
    send(6'h15, 0, 2'd1, 2, "R12 short stalled");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule